// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard arbiter for a pipeline that runs instructions out of order over several functional units without renaming. Decoded instructions arrive one at a time in program order, each naming the unit it needs, one destination register and two source registers. The controller accepts an instruction only when its unit is idle and no instruction still in flight will write the same destination. It then holds each unit back until both of the unit's source values can be read, and holds a finished unit's result until no older instruction still has to read the register that result will overwrite.

Three tables hold the state. The first is a per-unit entry: busy, operation, destination, both source registers, the unit producing each source and a ready flag per source. The second is a per-register record of the unit that will write that register. The third is a per-unit stage: waiting for operands, executing, or finished and waiting to write. Each unit's execution is modelled by a counter with a fixed latency set per unit by a parameter. The default set has an integer/load unit (latency 1), two multipliers (6), an adder (2) and a divider (10), at unit indices 0 to 4.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is busy, no register has a pending writer, and `rd_grant` and `wr_grant` are all zero.
- R2: An instruction is accepted (`in_valid` and `in_ready` in the same cycle) only when the unit at index `in_fu` exists and is not busy. `in_ready` is low for an index at or above the number of units. An accepted instruction marks its unit busy from the next cycle.
- R3: `in_ready` is low while any in-flight instruction has the same destination register as `in_dst`, even when the requested unit is free.
- R4: A unit whose source is being produced by another unit gets its read grant exactly one cycle after that producer's write grant.
- R5: A unit with no outstanding sources gets `rd_grant` one cycle after acceptance. Its operation code is presented on its slice of `rd_op` (unit i at bits i*OP_W and up) in that cycle. Its `exec_done` pulses LAT cycles after the read grant, and its write grant comes at the earliest one cycle after that.
- R6: A finished unit is not granted its write while an older unit still holds an unread source equal to its destination. It is granted in the cycle after that reader's read grant.
- R7: At most one `wr_grant` bit is high in any cycle. When several units are ready to write, the lowest unit index wins and the others wait.
- R8: In the cycle after a unit's write grant the unit is no longer busy, its destination's bit in `reg_pending` is clear, and a new instruction may be accepted into the unit.
- R9: A later instruction that does not depend on an earlier one is not held back by it: it may read, execute and write before the earlier one.
- R10: During a write grant, `wr_reg` carries the destination register of the granted unit, and that register's `reg_pending` bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_fu | input | FU_W | Index of the functional unit required |
| in_op | input | OP_W | Operation code handed to the unit |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Offered instruction can be issued this cycle |
| rd_grant | output | NUM_FU | Per unit: read operands and start executing |
| rd_op | output | NUM_FU*OP_W | Per unit operation code, valid with its read grant |
| exec_done | output | NUM_FU | Per unit completion notice from the execution counter |
| wr_grant | output | NUM_FU | Per unit: write the result this cycle |
| wr_reg | output | REG_W | Register written under the current write grant |
| fu_busy | output | NUM_FU | Unit holds an instruction |
| reg_pending | output | NUM_REG | Register has an in-flight writer |

## Verification
The bench targets the cycle counts around each hazard. Two back-to-back instructions for one unit must be spaced by exactly the release delay; a design that frees the unit late or early shifts that spacing. A write-after-write pair on different units must stall until the first write has retired; a design missing the destination check issues it at once. A read-after-write consumer must read exactly one cycle after its producer writes; a design that forgets to wake waiting units deadlocks into the watchdog. A write-after-read case, where an adder would overwrite a register still needed by a divider waiting on a multiplier, must hold the adder's write until the cycle after the divider reads; dropping this check lets the adder write four cycles early. Two units finishing in the same cycle must write one after the other, the lower index first.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OPS = 2'd1,
    ST_EXEC     = 2'd2,
    ST_DONE     = 2'd3
  } fu_stage_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sb_exec_timer.sv
module sb_exec_timer #(
  parameter int LAT = 1,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/sb_wr_pick.sv
module sb_wr_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // lowest index wins: isolate the lowest set bit
  assign gnt = req & (~req + N'(1));

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REG = 32,
  parameter int FU_W    = 3,
  parameter int REG_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [REG_W-1:0]   set_reg,
  input  logic [FU_W-1:0]    set_fu,
  input  logic               clr_en,
  input  logic [REG_W-1:0]   clr_reg,
  input  logic [REG_W-1:0]   rd_a,
  input  logic [REG_W-1:0]   rd_b,
  output logic [FU_W-1:0]    fu_a,
  output logic [FU_W-1:0]    fu_b,
  output logic [NUM_REG-1:0] pend
);

  // owner ids live in a plain memory with no reset; validity is a flop vector
  logic [FU_W-1:0]    owner_mem [NUM_REG];
  logic [NUM_REG-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (set_en) owner_mem[set_reg] <= set_fu;
  end

  assign fu_a = owner_mem[rd_a];
  assign fu_b = owner_mem[rd_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      if (clr_en) pend_q[clr_reg] <= 1'b0;
      if (set_en) pend_q[set_reg] <= 1'b1;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 5,
  parameter int NUM_REG = 32,
  parameter int OP_W    = 3,
  parameter logic [NUM_FU*8-1:0] LAT_TAB = {8'd10, 8'd2, 8'd6, 8'd6, 8'd1},
  localparam int FU_W  = idx_w(NUM_FU),
  localparam int REG_W = idx_w(NUM_REG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [FU_W-1:0]        in_fu,
  input  logic [OP_W-1:0]        in_op,
  input  logic [REG_W-1:0]       in_dst,
  input  logic [REG_W-1:0]       in_src1,
  input  logic [REG_W-1:0]       in_src2,
  output logic                   in_ready,
  output logic [NUM_FU-1:0]      rd_grant,
  output logic [NUM_FU*OP_W-1:0] rd_op,
  output logic [NUM_FU-1:0]      exec_done,
  output logic [NUM_FU-1:0]      wr_grant,
  output logic [REG_W-1:0]       wr_reg,
  output logic [NUM_FU-1:0]      fu_busy,
  output logic [NUM_REG-1:0]     reg_pending
);

  // functional unit status table
  logic [NUM_FU-1:0] busy_q, rj_q, rk_q;
  fu_stage_e         stage_q [NUM_FU];
  logic [OP_W-1:0]   op_q    [NUM_FU];
  logic [REG_W-1:0]  fi_q    [NUM_FU];
  logic [REG_W-1:0]  fj_q    [NUM_FU];
  logic [REG_W-1:0]  fk_q    [NUM_FU];
  logic [FU_W-1:0]   qj_q    [NUM_FU];
  logic [FU_W-1:0]   qk_q    [NUM_FU];

  logic [NUM_FU-1:0]  rd_req, wr_req, wr_gnt, war_hold, exe_done;
  logic [NUM_REG-1:0] pend_vec;
  logic [FU_W-1:0]    src1_fu, src2_fu, wr_idx;
  logic               fu_ok, issue_fire, wr_any, rj_init, rk_init;
  logic [REG_W-1:0]   wr_reg_w;

  // ---------------- issue stage: structural and WAW checks
  assign fu_ok    = ({1'b0, in_fu} < (FU_W + 1)'(NUM_FU));
  assign in_ready = fu_ok && !busy_q[in_fu] && !pend_vec[in_dst];
  assign issue_fire = in_valid && in_ready;

  // a source whose producer writes in this very cycle is ready at once
  assign rj_init = !pend_vec[in_src1] || (wr_any && (src1_fu == wr_idx));
  assign rk_init = !pend_vec[in_src2] || (wr_any && (src2_fu == wr_idx));

  // ---------------- register result status table
  sb_reg_status #(
    .NUM_REG (NUM_REG),
    .FU_W    (FU_W),
    .REG_W   (REG_W)
  ) u_rstat (
    .clk     (clk),
    .rst     (rst),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .set_fu  (in_fu),
    .clr_en  (wr_any),
    .clr_reg (wr_reg_w),
    .rd_a    (in_src1),
    .rd_b    (in_src2),
    .fu_a    (src1_fu),
    .fu_b    (src2_fu),
    .pend    (pend_vec)
  );

  // ---------------- per-unit execution counters and read requests
  for (genvar gi = 0; gi < NUM_FU; gi++) begin : g_unit
    localparam int UNIT_LAT = int'(LAT_TAB[gi*8 +: 8]);

    assign rd_req[gi] = (stage_q[gi] == ST_WAIT_OPS) && rj_q[gi] && rk_q[gi];
    assign wr_req[gi] = (stage_q[gi] == ST_DONE) && !war_hold[gi];
    assign rd_op[gi*OP_W +: OP_W] = op_q[gi];

    sb_exec_timer #(
      .LAT (UNIT_LAT)
    ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (rd_req[gi]),
      .done  (exe_done[gi])
    );
  end

  // ---------------- WAR check: an older reader still holds the old value
  always_comb begin
    for (int w = 0; w < NUM_FU; w++) begin
      war_hold[w] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != w && busy_q[f] &&
            ((rj_q[f] && (fj_q[f] == fi_q[w])) ||
             (rk_q[f] && (fk_q[f] == fi_q[w])))) begin
          war_hold[w] = 1'b1;
        end
      end
    end
  end

  // ---------------- write arbitration, one result per cycle
  sb_wr_pick #(
    .N (NUM_FU)
  ) u_pick (
    .req (wr_req),
    .gnt (wr_gnt)
  );

  always_comb begin
    wr_idx = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wr_gnt[i]) wr_idx = FU_W'(i);
    end
  end

  assign wr_any   = |wr_gnt;
  assign wr_reg_w = fi_q[wr_idx];

  // ---------------- control state of each unit
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      rj_q   <= '0;
      rk_q   <= '0;
      for (int i = 0; i < NUM_FU; i++) stage_q[i] <= ST_IDLE;
    end else begin
      for (int i = 0; i < NUM_FU; i++) begin
        if (wr_gnt[i]) begin
          busy_q[i]  <= 1'b0;
          stage_q[i] <= ST_IDLE;
        end else if (issue_fire && (in_fu == FU_W'(i))) begin
          busy_q[i]  <= 1'b1;
          stage_q[i] <= ST_WAIT_OPS;
          rj_q[i]    <= rj_init;
          rk_q[i]    <= rk_init;
        end else begin
          if (rd_req[i]) begin
            // operands consumed: flags drop so WAR no longer sees this reader
            stage_q[i] <= ST_EXEC;
            rj_q[i]    <= 1'b0;
            rk_q[i]    <= 1'b0;
          end else if (stage_q[i] == ST_WAIT_OPS && wr_any) begin
            if (!rj_q[i] && (qj_q[i] == wr_idx)) rj_q[i] <= 1'b1;
            if (!rk_q[i] && (qk_q[i] == wr_idx)) rk_q[i] <= 1'b1;
          end
          if (stage_q[i] == ST_EXEC && exe_done[i]) stage_q[i] <= ST_DONE;
        end
      end
    end
  end

  // ---------------- data fields of each unit, loaded at issue
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FU; i++) begin
      if (issue_fire && (in_fu == FU_W'(i))) begin
        op_q[i] <= in_op;
        fi_q[i] <= in_dst;
        fj_q[i] <= in_src1;
        fk_q[i] <= in_src2;
        qj_q[i] <= src1_fu;
        qk_q[i] <= src2_fu;
      end
    end
  end

  assign rd_grant    = rd_req;
  assign exec_done   = exe_done;
  assign wr_grant    = wr_gnt;
  assign wr_reg      = wr_reg_w;
  assign fu_busy     = busy_q;
  assign reg_pending = pend_vec;

endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 5,
  parameter int NUM_REG = 32,
  localparam int FU_W  = idx_w(NUM_FU),
  localparam int REG_W = idx_w(NUM_REG)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [FU_W-1:0]    in_fu,
  input logic [REG_W-1:0]   in_dst,
  input logic [NUM_FU-1:0]  rd_grant,
  input logic [NUM_FU-1:0]  wr_grant,
  input logic [REG_W-1:0]   wr_reg,
  input logic [NUM_FU-1:0]  fu_busy,
  input logic [NUM_REG-1:0] reg_pending
);

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_grant)); // R7

  AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> fu_busy[$past(in_fu)]); // R2

  AST_ISSUE_NO_WAW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> !reg_pending[in_dst]); // R3

  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rd_grant & ~fu_busy) == '0); // R4

  AST_WR_REG_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|wr_grant) |-> reg_pending[wr_reg]); // R10

  for (genvar gi = 0; gi < NUM_FU; gi++) begin : g_unit_chk
    AST_RELEASE_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
      wr_grant[gi] |=> !fu_busy[gi]); // R8

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
      rd_grant[gi] |=> !rd_grant[gi]); // R5
  end

endmodule

bind sb_hazard_ctrl sb_hazard_chk #(
  .NUM_FU  (NUM_FU),
  .NUM_REG (NUM_REG)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_fu       (in_fu),
  .in_dst      (in_dst),
  .rd_grant    (rd_grant),
  .wr_grant    (wr_grant),
  .wr_reg      (wr_reg),
  .fu_busy     (fu_busy),
  .reg_pending (reg_pending)
);

// File: tb/sb_hazard_ctrl_test.sv
module sb_hazard_ctrl_test;

  localparam int NFU  = 5;
  localparam int NREG = 32;
  localparam int OPW  = 3;
  localparam int FUW  = 3;
  localparam int RW   = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [FUW-1:0]  in_fu = '0;
  logic [OPW-1:0]  in_op = '0;
  logic [RW-1:0]   in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic            in_ready;
  logic [NFU-1:0]  rd_grant, exec_done, wr_grant, fu_busy;
  logic [NFU*OPW-1:0] rd_op;
  logic [RW-1:0]   wr_reg;
  logic [NREG-1:0] reg_pending;

  sb_hazard_ctrl uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fu(in_fu), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
    .rd_grant(rd_grant), .rd_op(rd_op), .exec_done(exec_done),
    .wr_grant(wr_grant), .wr_reg(wr_reg), .fu_busy(fu_busy),
    .reg_pending(reg_pending)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int unit; int rg; int cyc; int req;} exp_t;
  exp_t expq[$];
  int total = 0, bad = 0;
  int rd_cyc[NFU];
  int dn_cyc[NFU];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_wr(input int unit, input int rg, input int c, input int req);
    exp_t e;
    e.unit = unit; e.rg = rg; e.cyc = c; e.req = req;
    expq.push_back(e);
  endtask

  // monitor: records read/done cycles and compares each write against the queue
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < NFU; u++) begin
        if (rd_grant[u])  rd_cyc[u] = cyc;
        if (exec_done[u]) dn_cyc[u] = cyc;
      end
      if (wr_grant != '0) begin
        int wu;
        wu = -1;
        chk($onehot(wr_grant), "R7 one write per cycle", int'(wr_grant), 0);
        for (int u = 0; u < NFU; u++) if (wr_grant[u]) wu = u;
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected write", wu, -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          total++;
          if (e.unit != wu || e.rg != int'(wr_reg) || e.cyc != cyc) begin
            bad++;
            $display("FAIL R%0d write actual unit=%0d reg=%0d cyc=%0d expected unit=%0d reg=%0d cyc=%0d",
                     e.req, wu, wr_reg, cyc, e.unit, e.rg, e.cyc);
          end
        end
      end
    end
  end

  task automatic issue(input int fu, input int dst, input int s1, input int s2,
                       input int op, output int ic);
    @(negedge clk);
    in_valid = 1'b1;
    in_fu = FUW'(fu); in_dst = RW'(dst); in_src1 = RW'(s1); in_src2 = RW'(s2);
    in_op = OPW'(op);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    ic = cyc;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, b, d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fu_busy == '0, "R1 busy after reset", int'(fu_busy), 0);
    chk(reg_pending == '0, "R1 pending after reset", int'(reg_pending), 0);
    chk(wr_grant == '0 && rd_grant == '0, "R1 grants after reset", int'(wr_grant | rd_grant), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    // R2: a unit index beyond the last unit is never ready
    in_fu = 3'd7; #1;
    chk(in_ready == 1'b0, "R2 bad unit index", int'(in_ready), 0);
    in_fu = '0;

    // single add on unit 3: R5 timing, op handover, R8 release, R10 register
    issue(3, 1, 2, 3, 5, a);
    expect_wr(3, 1, a + 4, 10); // R10
    wait_cyc(a + 1);
    chk(reg_pending[1] == 1'b1, "R10 pending set", int'(reg_pending[1]), 1);
    chk(int'(rd_op[3*OPW +: OPW]) == 5, "R5 op handed over", int'(rd_op[3*OPW +: OPW]), 5);
    wait_cyc(a + 4);
    chk(fu_busy[3] == 1'b1, "R8 busy during write", int'(fu_busy[3]), 1);
    wait_cyc(a + 5);
    chk(fu_busy[3] == 1'b0, "R8 free after write", int'(fu_busy[3]), 0);
    chk(reg_pending[1] == 1'b0, "R8 pending cleared", int'(reg_pending[1]), 0);
    drain();
    chk(rd_cyc[3] == a + 1, "R5 read cycle", rd_cyc[3], a + 1);
    chk(dn_cyc[3] == a + 3, "R5 done cycle", dn_cyc[3], a + 3);

    // R2: structural stall on the same unit
    issue(3, 4, 0, 0, 1, a);
    expect_wr(3, 4, a + 4, 2); // R2
    issue(3, 5, 0, 0, 1, b);
    chk(b == a + 5, "R2 structural spacing", b - a, 5);
    expect_wr(3, 5, b + 4, 2);
    drain();

    // R3: WAW stall across different units
    issue(1, 6, 0, 0, 2, a);
    expect_wr(1, 6, a + 8, 3); // R3
    issue(3, 6, 0, 0, 2, b);
    chk(b == a + 9, "R3 waw spacing", b - a, 9);
    expect_wr(3, 6, b + 4, 3);
    drain();

    // R4 + R9: consumer waits on producer, independent op runs ahead
    issue(1, 8, 1, 2, 3, a);
    issue(3, 9, 8, 3, 3, b);
    issue(0, 10, 1, 1, 3, d);
    expect_wr(0, 10, d + 3, 9);  // R9
    expect_wr(1, 8, a + 8, 4);   // R4
    expect_wr(3, 9, a + 12, 4);
    drain();
    chk(rd_cyc[3] == a + 9, "R4 read after producer write", rd_cyc[3], a + 9);

    // R6: adder result held until the divider has read the old value
    issue(1, 0, 2, 4, 1, a);
    issue(4, 10, 0, 6, 1, b);
    issue(3, 6, 8, 2, 1, d);
    expect_wr(1, 0, a + 8, 6);   // R6
    expect_wr(3, 6, a + 10, 6);
    expect_wr(4, 10, a + 20, 6);
    drain();
    chk(rd_cyc[4] == a + 9, "R6 divider read", rd_cyc[4], a + 9);

    // R7: simultaneous finish, lower index writes first
    issue(3, 11, 0, 0, 0, a);
    issue(0, 12, 0, 0, 0, b);
    expect_wr(0, 12, a + 4, 7);  // R7
    expect_wr(3, 11, a + 5, 7);
    drain();

    chk(expq.size() == 0, "R9 all writes seen", expq.size(), 0);
    chk(fu_busy == '0, "R8 all units idle", int'(fu_busy), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule